// File: doc/BRIEF.md
# Hart-Local Timer and Software Interrupt Unit

This unit gives a single hart its machine-level timer interrupt and software interrupt. It keeps a 64-bit time count that steps forward on rising edges of a slow real-time tick input, not on every core clock. It also keeps a 64-bit deadline value. The timer interrupt line is high whenever the count has reached or passed the deadline. A separate one-bit register drives the software interrupt line, so one hart (or the hart itself) can raise an interrupt by writing to it.

Software reaches every register through a plain 32-bit register bus that reads combinationally. Each 64-bit register is split into a low word and a high word. The tick input comes from a slower clock. It passes through a short flop synchronizer, and an edge detector follows it. Software can still overwrite the time count at any moment.

Top module: `hart_timer_irq`

## Requirements
- R1: After reset the time count is zero, the deadline is all ones, the software bit is zero, and both interrupt lines are low.
- R2: The time count rises by exactly one for each rising edge of the tick input, after it passes the synchronizer. A falling edge does not advance it, and neither does a tick that stays high for many clocks.
- R3: The time count is a full 64-bit counter. An increment from a low word of all ones carries into the high word.
- R4: `timer_irq_o` is high exactly when the time count, read as unsigned 64 bits, is greater than or equal to the deadline.
- R5: Raising the deadline above the time count drops `timer_irq_o` in the cycle right after the write edge. Lowering the deadline to or below the count raises it in that same cycle.
- R6: Word map (byte address, bits [1:0] ignored): 0x00 software bit, 0x08 deadline low, 0x0C deadline high, 0x10 count low, 0x14 count high. A write to one half changes only that half.
- R7: The software register keeps only data bit 0, and `soft_irq_o` follows it. Its bits 31:1 read as zero, and writes to them have no effect.
- R8: If a write to either count half lands in the same cycle as a tick increment, the write wins. The written half takes the bus data, the other half keeps its value, and that increment is dropped.
- R9: Reads of unmapped addresses (0x04, 0x18, 0x1C) return zero, and writes to them change no register.
- R10: A read returns the current value of the addressed register word in the same cycle, with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_src_i | input | 1 | Slow real-time tick, asynchronous to clk |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | High for a write, low for a read |
| bus_addr_i | input | ADDR_W (5) | Byte address of the register word |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Combinational read data |
| timer_irq_o | output | 1 | Timer interrupt pending |
| soft_irq_o | output | 1 | Software interrupt pending |

## Verification
The assertions check, on every cycle, that the count moves only by a single step or by a bus write, that the deadline changes only when written, that a count write lands exactly and leaves the other half alone, and that the software bit and its upper read bits behave as specified. Some behaviour shows up only in the bench's scenarios. These are the end-to-end mapping from a tick edge to exactly one increment after the synchronizer delay, the carry across the word boundary, and the interrupt level as the deadline moves around the count. The same holds for an increment lost to a coinciding write, and for the silence of unmapped addresses.

// File: rtl/hti_pkg.sv
package hti_pkg;

   localparam int IDX_W = 3;

   // Word index = byte address [4:2]
   typedef enum logic [IDX_W-1:0] {
      W_SOFT   = 3'd0,
      W_CMP_LO = 3'd2,
      W_CMP_HI = 3'd3,
      W_CNT_LO = 3'd4,
      W_CNT_HI = 3'd5
   } word_idx_e;

endpackage

// File: rtl/hti_tick_edge.sv
module hti_tick_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   output logic rise_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], tick_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/hti_split_reg.sv
module hti_split_reg #(
   parameter int                    HALF_W    = 32,
   parameter bit                    HAS_INC   = 1'b0,
   parameter logic [2*HALF_W-1:0]   RESET_VAL = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_lo_i,
   input  logic                wr_hi_i,
   input  logic [HALF_W-1:0]   wdata_i,
   input  logic                inc_i,
   output logic [2*HALF_W-1:0] q_o
);

   localparam int FULL_W = 2 * HALF_W;

   logic              inc_eff;
   logic [FULL_W-1:0] nxt;

   generate
      if (HAS_INC) begin : g_counter
         assign inc_eff = inc_i;
      end else begin : g_plain
         logic unused_inc;
         assign unused_inc = inc_i;
         assign inc_eff    = 1'b0;
      end
   endgenerate

   // Software write has priority over an increment
   always_comb begin
      nxt = q_o;
      if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) nxt[HALF_W-1:0]      = wdata_i;
         if (wr_hi_i) nxt[FULL_W-1:HALF_W] = wdata_i;
      end else if (inc_eff) begin
         nxt = q_o + FULL_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RESET_VAL;
      else        q_o <= nxt;
   end

endmodule

// File: rtl/hart_timer_irq.sv
module hart_timer_irq
   import hti_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 64,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_src_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              timer_irq_o,
   output logic              soft_irq_o
);

   localparam int HALF_W = CNT_W / 2;

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_width
         $error("CNT_W must be twice DATA_W");
      end
      if (ADDR_W != IDX_W + 2) begin : g_bad_addr
         $error("ADDR_W must equal word index width plus 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] widx;
   logic             wr;
   logic             soft_q;
   logic             tick_rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cmp_q;
   logic [1:0]       unused_lsb;

   assign widx       = bus_addr_i[IDX_W+1:2];
   assign unused_lsb = bus_addr_i[1:0];
   assign wr         = bus_sel_i & bus_wr_i;

   hti_tick_edge #(.STAGES(SYNC_STAGES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_src_i),
      .rise_o (tick_rise)
   );

   hti_split_reg #(
      .HALF_W   (HALF_W),
      .HAS_INC  (1'b1),
      .RESET_VAL({CNT_W{1'b0}})
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo_i (wr && widx == W_CNT_LO),
      .wr_hi_i (wr && widx == W_CNT_HI),
      .wdata_i (bus_wdata_i),
      .inc_i   (tick_rise),
      .q_o     (cnt_q)
   );

   hti_split_reg #(
      .HALF_W   (HALF_W),
      .HAS_INC  (1'b0),
      .RESET_VAL({CNT_W{1'b1}})
   ) u_deadline (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo_i (wr && widx == W_CMP_LO),
      .wr_hi_i (wr && widx == W_CMP_HI),
      .wdata_i (bus_wdata_i),
      .inc_i   (1'b0),
      .q_o     (cmp_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        soft_q <= 1'b0;
      else if (wr && widx == W_SOFT)     soft_q <= bus_wdata_i[0];
   end

   always_comb begin
      case (widx)
         W_SOFT:   bus_rdata_o = {{(DATA_W-1){1'b0}}, soft_q};
         W_CMP_LO: bus_rdata_o = cmp_q[HALF_W-1:0];
         W_CMP_HI: bus_rdata_o = cmp_q[CNT_W-1:HALF_W];
         W_CNT_LO: bus_rdata_o = cnt_q[HALF_W-1:0];
         W_CNT_HI: bus_rdata_o = cnt_q[CNT_W-1:HALF_W];
         default:  bus_rdata_o = '0;
      endcase
   end

   assign timer_irq_o = (cnt_q >= cmp_q);
   assign soft_irq_o  = soft_q;

endmodule

// File: rtl/hti_checker.sv
module hti_checker
   import hti_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel_i,
   input logic              bus_wr_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              soft_irq_o,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cmp,
   input logic              tick_rise
);

   localparam int HALF_W = CNT_W / 2;

   logic [IDX_W-1:0] idx;
   logic             wr, wr_cnt_lo, wr_cnt_hi, wr_cmp, wr_soft;

   assign idx       = bus_addr_i[IDX_W+1:2];
   assign wr        = bus_sel_i && bus_wr_i;
   assign wr_cnt_lo = wr && idx == W_CNT_LO;
   assign wr_cnt_hi = wr && idx == W_CNT_HI;
   assign wr_cmp    = wr && (idx == W_CMP_LO || idx == W_CMP_HI);
   assign wr_soft   = wr && idx == W_SOFT;

   // R2: without a write the count holds or steps by one
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_cnt_lo || wr_cnt_hi) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

   // R2: no tick edge and no write means no change
   p_count_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_cnt_lo || wr_cnt_hi) && !tick_rise) |=> $stable(cnt));

   // R6: deadline changes only when written
   p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cmp |=> $stable(cmp));

   // R8: low-half write lands exactly, high half kept, increment dropped
   p_lo_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_lo |=> (cnt[HALF_W-1:0] == $past(bus_wdata_i)
                     && cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W])));

   // R8: high-half write lands exactly, low half kept
   p_hi_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt_hi |=> (cnt[CNT_W-1:HALF_W] == $past(bus_wdata_i)
                     && cnt[HALF_W-1:0] == $past(cnt[HALF_W-1:0])));

   // R7: software line follows bit 0 of the last write
   p_soft_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_soft |=> soft_irq_o == $past(bus_wdata_i[0]));

   // R7: upper bits of the software word read as zero
   p_soft_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idx == W_SOFT) |-> bus_rdata_o[DATA_W-1:1] == '0);

endmodule

bind hart_timer_irq hti_checker #(
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel_i   (bus_sel_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .soft_irq_o  (soft_irq_o),
   .cnt         (cnt_q),
   .cmp         (cmp_q),
   .tick_rise   (tick_rise)
);

// File: tb/hart_timer_irq_tb_top.sv
module hart_timer_irq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        t_irq, s_irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [63:0] exp_cnt;
   logic [63:0] exp_cmp;
   logic        exp_soft;

   always #2 clk = ~clk;

   hart_timer_irq dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_src_i  (tick),
      .bus_sel_i   (sel),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .timer_irq_o (t_irq),
      .soft_irq_o  (s_irq)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   function automatic logic [31:0] model_read(input logic [4:0] a);
      case (a[4:2])
         3'd0:    return {31'd0, exp_soft};
         3'd2:    return exp_cmp[31:0];
         3'd3:    return exp_cmp[63:32];
         3'd4:    return exp_cnt[31:0];
         3'd5:    return exp_cnt[63:32];
         default: return 32'd0;
      endcase
   endfunction

   function automatic void model_write(input logic [4:0] a, input logic [31:0] d);
      case (a[4:2])
         3'd0: exp_soft       = d[0];
         3'd2: exp_cmp[31:0]  = d;
         3'd3: exp_cmp[63:32] = d;
         3'd4: exp_cnt[31:0]  = d;
         3'd5: exp_cnt[63:32] = d;
         default: ;
      endcase
   endfunction

   task automatic do_write(input logic [4:0] a, input logic [31:0] d);
      bus_write(a, d);
      model_write(a, d);
   endtask

   task automatic tick_pulse(input int hi_cycles);
      @(negedge clk); tick = 1'b1;
      repeat (hi_cycles) @(negedge clk);
      tick = 1'b0;
      repeat (5) @(negedge clk);
      exp_cnt = exp_cnt + 64'd1;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] d;
      for (int w = 0; w < 8; w++) begin
         bus_read(5'(w * 4), d);
         check($sformatf("%s R10 word%0d", tag, w), {32'd0, d}, {32'd0, model_read(5'(w * 4))});
      end
      #1;
      check({tag, " R4 timer_irq"}, {63'd0, t_irq}, {63'd0, (exp_cnt >= exp_cmp)});
      check({tag, " R7 soft_irq"}, {63'd0, s_irq}, {63'd0, exp_soft});
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd7031));
      exp_cnt = 64'd0; exp_cmp = '1; exp_soft = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 timer_irq at reset", {63'd0, t_irq}, 64'd0);
      check("R1 soft_irq at reset", {63'd0, s_irq}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      check_all("R1");

      // R2 one step per edge, long high counts once
      tick_pulse(2);
      check_all("R2 short pulse");
      tick_pulse(25);
      check_all("R2 long pulse");

      // R3 carry across words
      do_write(5'h10, 32'hFFFF_FFFF);
      do_write(5'h14, 32'h0000_0007);
      tick_pulse(3);
      check_all("R3 carry");
      bus_read(5'h14, d);
      check("R3 high word after carry", {32'd0, d}, 64'h8);

      // R4/R5 deadline moves
      do_write(5'h0C, exp_cnt[63:32]);
      do_write(5'h08, exp_cnt[31:0]);
      check_all("R4 equal");
      do_write(5'h08, exp_cnt[31:0] + 32'd1);
      #1 check("R5 raise clears", {63'd0, t_irq}, 64'd0);
      tick_pulse(2);
      check_all("R4 reach");
      do_write(5'h0C, exp_cnt[63:32] + 32'd1);
      #1 check("R5 high-word raise clears", {63'd0, t_irq}, 64'd0);

      // R6 halves independent
      do_write(5'h08, 32'hA5A5_0001);
      check_all("R6 low only");

      // R7 upper bits ignored
      do_write(5'h00, 32'hFFFF_FFFE);
      check_all("R7 bit0 clear");
      do_write(5'h00, 32'h8000_0001);
      check_all("R7 bit0 set");

      // R9 unmapped writes
      do_write(5'h04, 32'hDEAD_BEEF);
      do_write(5'h18, 32'h1234_5678);
      do_write(5'h1C, 32'hFFFF_FFFF);
      check_all("R9 unmapped");

      // R8 write coincides with increment edge
      @(negedge clk); tick = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = 5'h10; wdata = 32'h0000_0100;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
      exp_cnt[31:0] = 32'h0000_0100;
      repeat (4) @(negedge clk);
      tick = 1'b0;
      repeat (5) @(negedge clk);
      check_all("R8 write wins");

      // Constrained random mix
      for (int i = 0; i < 300; i++) begin
         int op;
         op = int'($urandom % 5);
         case (op)
            0: tick_pulse(1 + int'($urandom % 6));
            1: begin
               logic [2:0] w;
               w = 3'($urandom % 8);
               do_write({w, 2'b00}, $urandom);
            end
            2: begin
               logic [63:0] c;
               c = exp_cnt + 64'($urandom % 4) - 64'd1;
               do_write(5'h0C, c[63:32]);
               do_write(5'h08, c[31:0]);
            end
            3: do_write(5'h10, 32'hFFFF_FFFF - 32'($urandom % 3));
            default: do_write(5'h00, $urandom);
         endcase
         if (i % 10 == 9) check_all($sformatf("rand%0d", i));
      end
      check_all("final");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule